// File: doc/BRIEF.md
# Dual-Issue Even/Odd Pair Issuer

This block sits between an instruction buffer and two execution pipes, called the even pipe and the odd pipe. It takes in aligned instruction pairs. Each pair holds an instruction from an even address (slot 0) and one from the following odd address (slot 1). Each cycle the block sends out zero, one or two instructions, strictly in program order. Every instruction arrives already decoded into a packed word. The word gives the pipe class of the instruction, two source registers, an optional destination register, and a flag that marks a local-memory access.

Two instructions leave together only when slot 0 belongs to the even pipe and slot 1 belongs to the odd pipe. In every other case slot 0 leaves first and slot 1 leaves in a later cycle. A register scoreboard holds back any instruction that reads or writes a register still owed by an older instruction. Writeback ports clear those register marks. A memory instruction requests the local-memory arbiter and waits in the issue stage until it receives a grant in the same cycle. A flush drops every pair the block holds.

Top module: `pair_issuer`

## Requirements
- R1: Instruction word layout: bits [RW-1:0] are source A, [2RW-1:RW] are source B, [3RW-1:2RW] are the destination, bit 3RW is destination-used, bit 3RW+1 is memory-access, and bit 3RW+2 is pipe class (0 = even, 1 = odd). RW = log2(NREG), so the default layout is 24 bits. While reset is held and in the first cycle after it, no output is valid, `mem_req` is low and `in_ready` is high.
- R2: A pair accepted on one rising edge, with no hazard and no memory access, is dispatched by the registers updated on the third rising edge, counting the accepting edge as the first.
- R3: Both instructions of a pair dispatch on the same edge only when slot 0 has class even and slot 1 has class odd. Otherwise slot 0 dispatches alone and slot 1 dispatches no earlier than the next edge.
- R4: Each instruction appears on the output of the pipe that its class bit names. `out_*_slot` is 0 for a slot-0 instruction and 1 for a slot-1 instruction.
- R5: Instructions dispatch in exactly the order they were accepted (slot 0 before slot 1, pair after pair). None is lost and none is duplicated.
- R6: When `in_odd_entry` is set with a pair, slot 0 is discarded and only slot 1 dispatches.
- R7: A memory-access instruction dispatches only on an edge where `mem_gnt` was high. `mem_req` is high while the oldest ready instruction is a memory access. At most one memory-access instruction dispatches per edge.
- R8: An instruction does not dispatch while a source register, or its used destination, is marked busy. Dispatch of an instruction whose destination is used marks that register busy. A writeback clears the mark, and with WB_BYPASS = 1 an instruction can dispatch on the same edge as that writeback.
- R9: Slot 1 does not pair with slot 0 when it reads or rewrites the register that slot 0 writes.
- R10: On an edge with `flush` high nothing dispatches, and every held pair is dropped. Nothing from those pairs dispatches afterwards.
- R11: `in_ready` is low while `flush` is high, and also while a pair waits in the capture stage behind a held pair that cannot fully drain this cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drop all held pairs, dispatch nothing this cycle |
| in_valid | input | 1 | A pair is offered |
| in_ready | output | 1 | The offered pair is taken at the next edge |
| in_even_word | input | IW | Slot 0 (even address) instruction word |
| in_odd_word | input | IW | Slot 1 (odd address) instruction word |
| in_odd_entry | input | 1 | Pair was entered at its odd address; slot 0 is invalid |
| mem_gnt | input | 1 | Local-memory cycle granted this cycle |
| mem_req | output | 1 | A ready memory instruction is waiting |
| wb_valid | input | NWB | Writeback strobes, one per port |
| wb_reg | input | NWB*RW | Writeback register numbers, port k at [k*RW +: RW] |
| out_even_valid | output | 1 | Even pipe receives an instruction |
| out_even_word | output | IW | Instruction word sent to the even pipe |
| out_even_slot | output | 1 | Slot the even-pipe instruction came from |
| out_odd_valid | output | 1 | Odd pipe receives an instruction |
| out_odd_word | output | IW | Instruction word sent to the odd pipe |
| out_odd_slot | output | 1 | Slot the odd-pipe instruction came from |

## Verification
A writeback that clears a busy register can land on the same edge as a memory grant. It can also land on the same edge as a flush or a dual dispatch, so a scoreboard clear, a scoreboard set, a grant and a pair decision can all resolve in one cycle. The bench provokes these overlaps with random grants, random writebacks drawn from the registers it knows are owed, and rare random flushes. It judges the dispatch stream against its own program-order queue and its own busy-register table: every dispatched word must be the next expected one, must not touch a register the table still holds, and must follow a high grant if it accesses memory. Directed cases pin down the exact edge of dispatch for latency, split pairs, odd entry, memory wait, dependency stalls and flush.

// File: rtl/pair_issue_pkg.sv
package pair_issue_pkg;

   typedef enum logic {
      PIPE_EVEN = 1'b0,
      PIPE_ODD  = 1'b1
   } pipe_e;

   // Field offsets inside an instruction word, derived from the register index width.
   function automatic int f_srca(input int rw);  return 0;        endfunction
   function automatic int f_srcb(input int rw);  return rw;       endfunction
   function automatic int f_dst(input int rw);   return 2 * rw;   endfunction
   function automatic int f_duse(input int rw);  return 3 * rw;   endfunction
   function automatic int f_mem(input int rw);   return 3 * rw + 1; endfunction
   function automatic int f_pipe(input int rw);  return 3 * rw + 2; endfunction
   function automatic int f_width(input int rw); return 3 * rw + 3; endfunction

endpackage

// File: rtl/pair_issue_buffer.sv
module pair_issue_buffer #(
   parameter int IW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          in_valid,
   input  logic [IW-1:0] in_even_word,
   input  logic [IW-1:0] in_odd_word,
   input  logic          in_odd_entry,
   output logic          in_ready,
   input  logic          take0,
   input  logic          take1,
   output logic          h0_v,
   output logic          h1_v,
   output logic [IW-1:0] h_even,
   output logic [IW-1:0] h_odd
);

   logic          cap_v;
   logic          cap_oe;
   logic [IW-1:0] cap_e;
   logic [IW-1:0] cap_o;
   logic          hold_done;

   // The held pair is finished when every still-valid slot is taken this cycle.
   assign hold_done = (!h0_v || take0) && (!h1_v || take1);
   assign in_ready  = !flush && (!cap_v || hold_done);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_v  <= 1'b0;
         cap_oe <= 1'b0;
         cap_e  <= '0;
         cap_o  <= '0;
         h0_v   <= 1'b0;
         h1_v   <= 1'b0;
         h_even <= '0;
         h_odd  <= '0;
      end else if (flush) begin
         cap_v <= 1'b0;
         h0_v  <= 1'b0;
         h1_v  <= 1'b0;
      end else begin
         if (hold_done) begin
            h0_v   <= cap_v && !cap_oe;
            h1_v   <= cap_v;
            h_even <= cap_e;
            h_odd  <= cap_o;
         end else begin
            if (take0) h0_v <= 1'b0;
            if (take1) h1_v <= 1'b0;
         end
         if (in_valid && in_ready) begin
            cap_v  <= 1'b1;
            cap_oe <= in_odd_entry;
            cap_e  <= in_even_word;
            cap_o  <= in_odd_word;
         end else if (hold_done) begin
            cap_v <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/pair_issue_scoreboard.sv
module pair_issue_scoreboard #(
   parameter int NREG      = 128,
   parameter int NWB       = 2,
   parameter bit WB_BYPASS = 1'b1,
   localparam int RW       = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NWB-1:0]    wb_valid,
   input  logic [NWB*RW-1:0] wb_reg,
   input  logic              set0_v,
   input  logic [RW-1:0]     set0_r,
   input  logic              set1_v,
   input  logic [RW-1:0]     set1_r,
   output logic [NREG-1:0]   busy
);

   logic [NREG-1:0] sb_q;
   logic [NREG-1:0] clr_mask;
   logic [NREG-1:0] set_mask;

   always_comb begin
      clr_mask = '0;
      for (int k = 0; k < NWB; k++) begin
         if (wb_valid[k]) clr_mask[wb_reg[k*RW +: RW]] = 1'b1;
      end
   end

   always_comb begin
      set_mask = '0;
      if (set0_v) set_mask[set0_r] = 1'b1;
      if (set1_v) set_mask[set1_r] = 1'b1;
   end

   generate
      if (WB_BYPASS) begin : g_bypass
         assign busy = sb_q & ~clr_mask;
      end else begin : g_registered
         assign busy = sb_q;
      end
   endgenerate

   // A new set wins over a clear of the same register on the same edge.
   always_ff @(posedge clk) begin
      if (!rst_n) sb_q <= '0;
      else        sb_q <= (sb_q & ~clr_mask) | set_mask;
   end

endmodule

// File: rtl/pair_issue_pick.sv
module pair_issue_pick
   import pair_issue_pkg::*;
#(
   parameter int NREG = 128,
   localparam int RW  = $clog2(NREG),
   localparam int IW  = 3 * RW + 3
) (
   input  logic            flush,
   input  logic            h0_v,
   input  logic            h1_v,
   input  logic [IW-1:0]   we,
   input  logic [IW-1:0]   wo,
   input  logic [NREG-1:0] busy,
   input  logic            mem_gnt,
   output logic            take0,
   output logic            take1,
   output logic            mem_req
);

   localparam int SA = f_srca(RW);
   localparam int SB = f_srcb(RW);
   localparam int DS = f_dst(RW);
   localparam int DU = f_duse(RW);
   localparam int MB = f_mem(RW);
   localparam int PB = f_pipe(RW);

   logic hz_e, hz_o;
   logic rdy0, rdy1, pair_ok, dep, join_ok;

   assign hz_e = busy[we[SA +: RW]] || busy[we[SB +: RW]] || (we[DU] && busy[we[DS +: RW]]);
   assign hz_o = busy[wo[SA +: RW]] || busy[wo[SB +: RW]] || (wo[DU] && busy[wo[DS +: RW]]);

   always_comb begin
      rdy0    = h0_v && !hz_e;
      pair_ok = (pipe_e'(we[PB]) == PIPE_EVEN) && (pipe_e'(wo[PB]) == PIPE_ODD);
      dep     = we[DU] && ((wo[SA +: RW] == we[DS +: RW]) ||
                           (wo[SB +: RW] == we[DS +: RW]) ||
                           (wo[DU] && (wo[DS +: RW] == we[DS +: RW])));
      join_ok = rdy0 && pair_ok && !dep && !(we[MB] && wo[MB]);
      rdy1    = h1_v && !hz_o && (h0_v ? join_ok : 1'b1);
      take0   = !flush && rdy0 && (!we[MB] || mem_gnt);
      take1   = !flush && rdy1 && (!wo[MB] || mem_gnt) && (!h0_v || take0);
      mem_req = !flush && ((rdy0 && we[MB]) || (rdy1 && wo[MB]));
   end

endmodule

// File: rtl/pair_issuer.sv
module pair_issuer
   import pair_issue_pkg::*;
#(
   parameter int NREG      = 128,
   parameter int NWB       = 2,
   parameter bit WB_BYPASS = 1'b1,
   localparam int RW       = $clog2(NREG),
   localparam int IW       = 3 * RW + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [IW-1:0]     in_even_word,
   input  logic [IW-1:0]     in_odd_word,
   input  logic              in_odd_entry,
   input  logic              mem_gnt,
   output logic              mem_req,
   input  logic [NWB-1:0]    wb_valid,
   input  logic [NWB*RW-1:0] wb_reg,
   output logic              out_even_valid,
   output logic [IW-1:0]     out_even_word,
   output logic              out_even_slot,
   output logic              out_odd_valid,
   output logic [IW-1:0]     out_odd_word,
   output logic              out_odd_slot
);

   localparam int DS = f_dst(RW);
   localparam int DU = f_duse(RW);
   localparam int PB = f_pipe(RW);

   generate
      if (NREG < 4 || (1 << RW) != NREG) begin : g_bad_nreg
         $error("pair_issuer: NREG must be a power of two of at least 4");
      end
      if (NWB < 1 || NWB > 8) begin : g_bad_nwb
         $error("pair_issuer: NWB must lie between 1 and 8");
      end
      if (IW != f_width(RW)) begin : g_bad_iw
         $error("pair_issuer: word width does not match the field layout");
      end
   endgenerate

   logic            h0_v, h1_v;
   logic [IW-1:0]   h_even, h_odd;
   logic            take0, take1;
   logic [NREG-1:0] busy;

   pair_issue_buffer #(.IW(IW)) u_buf (
      .clk          (clk),
      .rst_n        (rst_n),
      .flush        (flush),
      .in_valid     (in_valid),
      .in_even_word (in_even_word),
      .in_odd_word  (in_odd_word),
      .in_odd_entry (in_odd_entry),
      .in_ready     (in_ready),
      .take0        (take0),
      .take1        (take1),
      .h0_v         (h0_v),
      .h1_v         (h1_v),
      .h_even       (h_even),
      .h_odd        (h_odd)
   );

   pair_issue_pick #(.NREG(NREG)) u_pick (
      .flush   (flush),
      .h0_v    (h0_v),
      .h1_v    (h1_v),
      .we      (h_even),
      .wo      (h_odd),
      .busy    (busy),
      .mem_gnt (mem_gnt),
      .take0   (take0),
      .take1   (take1),
      .mem_req (mem_req)
   );

   pair_issue_scoreboard #(.NREG(NREG), .NWB(NWB), .WB_BYPASS(WB_BYPASS)) u_sb (
      .clk      (clk),
      .rst_n    (rst_n),
      .wb_valid (wb_valid),
      .wb_reg   (wb_reg),
      .set0_v   (take0 && h_even[DU]),
      .set0_r   (h_even[DS +: RW]),
      .set1_v   (take1 && h_odd[DU]),
      .set1_r   (h_odd[DS +: RW]),
      .busy     (busy)
   );

   // Dispatch registers: each taken instruction lands on the pipe its class bit names.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_even_valid <= 1'b0;
         out_even_word  <= '0;
         out_even_slot  <= 1'b0;
         out_odd_valid  <= 1'b0;
         out_odd_word   <= '0;
         out_odd_slot   <= 1'b0;
      end else begin
         out_even_valid <= 1'b0;
         out_odd_valid  <= 1'b0;
         if (take0) begin
            if (pipe_e'(h_even[PB]) == PIPE_EVEN) begin
               out_even_valid <= 1'b1;
               out_even_word  <= h_even;
               out_even_slot  <= 1'b0;
            end else begin
               out_odd_valid <= 1'b1;
               out_odd_word  <= h_even;
               out_odd_slot  <= 1'b0;
            end
         end
         if (take1) begin
            if (pipe_e'(h_odd[PB]) == PIPE_EVEN) begin
               out_even_valid <= 1'b1;
               out_even_word  <= h_odd;
               out_even_slot  <= 1'b1;
            end else begin
               out_odd_valid <= 1'b1;
               out_odd_word  <= h_odd;
               out_odd_slot  <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/pair_issue_checker.sv
module pair_issue_checker (
   input logic clk,
   input logic rst_n,
   input logic flush,
   input logic in_ready,
   input logic mem_gnt,
   input logic ev_valid,
   input logic ev_slot,
   input logic ev_class,
   input logic ev_mem,
   input logic od_valid,
   input logic od_slot,
   input logic od_class,
   input logic od_mem
);

   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> !ev_valid && !od_valid);

   a_r3_pair_slots: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid && od_valid |-> !ev_slot && od_slot);

   a_r4_even_class: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid |-> !ev_class);

   a_r4_odd_class: assert property (@(posedge clk) disable iff (!rst_n)
      od_valid |-> od_class);

   a_r7_mem_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && ev_mem) || (od_valid && od_mem) |-> $past(mem_gnt));

   a_r7_single_mem: assert property (@(posedge clk) disable iff (!rst_n)
      !(ev_valid && ev_mem && od_valid && od_mem));

   a_r10_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !ev_valid && !od_valid);

   a_r11_flush_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !in_ready);

endmodule

bind pair_issuer pair_issue_checker u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .flush    (flush),
   .in_ready (in_ready),
   .mem_gnt  (mem_gnt),
   .ev_valid (out_even_valid),
   .ev_slot  (out_even_slot),
   .ev_class (out_even_word[IW-1]),
   .ev_mem   (out_even_word[IW-2]),
   .od_valid (out_odd_valid),
   .od_slot  (out_odd_slot),
   .od_class (out_odd_word[IW-1]),
   .od_mem   (out_odd_word[IW-2])
);

// File: tb/pair_issuer_tb_top.sv
`timescale 1ns/1ps
module pair_issuer_tb_top;

   localparam int NREG = 128;
   localparam int NWB  = 2;
   localparam int RW   = 7;
   localparam int IW   = 24;
   localparam int DU   = 3 * RW;
   localparam int QN   = 256;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic              flush = 1'b0;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [IW-1:0]     in_even_word = '0;
   logic [IW-1:0]     in_odd_word = '0;
   logic              in_odd_entry = 1'b0;
   logic              mem_gnt = 1'b0;
   logic              mem_req;
   logic [NWB-1:0]    wb_valid = '0;
   logic [NWB*RW-1:0] wb_reg = '0;
   logic              out_even_valid, out_even_slot, out_odd_valid, out_odd_slot;
   logic [IW-1:0]     out_even_word, out_odd_word;

   pair_issuer #(.NREG(NREG), .NWB(NWB), .WB_BYPASS(1'b1)) dut_i (.*);

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;
   bit mon_en   = 0;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [IW-1:0] mk(input bit pipe, input bit mem, input bit du,
                                        input int dst, input int sb, input int sa);
      return {pipe, mem, du, dst[RW-1:0], sb[RW-1:0], sa[RW-1:0]};
   endfunction

   // Bench model: program-order queue and table of owed registers.
   logic [IW-1:0] q_w [QN];
   bit            q_s [QN];
   int            q_p [QN];
   int            qh = 0, qt = 0, pid = 0, dual_pid = 0;
   bit            pend [NREG];

   task automatic push(input logic [IW-1:0] w, input bit s, input int p);
      q_w[qt] = w; q_s[qt] = s; q_p[qt] = p;
      qt = (qt + 1) % QN;
   endtask

   task automatic see(input logic [IW-1:0] w, input logic s, input logic p, input logic dual);
      int ra, rb, rd;
      ra = int'(w[RW-1:0]);
      rb = int'(w[2*RW-1:RW]);
      rd = int'(w[3*RW-1:2*RW]);
      chk(qh != qt, "R5", "dispatch with nothing expected", 1, 0);
      if (qh == qt) return;
      chk(w == q_w[qh] && s == q_s[qh], "R5", "dispatched word out of order", int'(w), int'(q_w[qh]));
      chk(w[IW-1] == p, "R4", "class bit versus pipe", int'(w[IW-1]), int'(p));
      chk(!pend[ra] && !pend[rb] && !(w[DU] && pend[rd]), "R8", "dispatch on busy register", ra, rd);
      if (w[IW-2]) chk(mem_gnt, "R7", "memory dispatch without grant", int'(mem_gnt), 1);
      if (dual) begin
         if (!p) chk(!s, "R3", "dual even-pipe slot", int'(s), 0);
         else    chk(s && q_p[qh] == dual_pid, "R3", "dual odd-pipe slot or pair", int'(s), 1);
      end
      if (!p) dual_pid = q_p[qh];
      if (w[DU]) pend[rd] = 1'b1;
      qh = (qh + 1) % QN;
   endtask

   always @(negedge clk) begin
      if (rst_n && mon_en) begin
         for (int k = 0; k < NWB; k++)
            if (wb_valid[k]) pend[wb_reg[k*RW +: RW]] = 1'b0;
         if (flush) chk(!out_even_valid && !out_odd_valid, "R10", "dispatch on flush edge",
                        int'(out_even_valid) + int'(out_odd_valid), 0);
         if (out_even_valid) see(out_even_word, out_even_slot, 1'b0, out_odd_valid);
         if (out_odd_valid)  see(out_odd_word,  out_odd_slot,  1'b1, out_even_valid);
         if (out_even_valid && out_odd_valid)
            chk(!(out_even_word[IW-2] && out_odd_word[IW-2]), "R7", "two memory dispatches", 2, 1);
      end
   end

   // Driver state
   int            gmode = 1;
   bit            wb_auto = 0, flush_req = 0, acc_last = 0, load_req = 0, wb_force = 0;
   int            wb_force_reg = 0;
   logic [IW-1:0] ld_e, ld_o;
   bit            ld_oe;

   task automatic cyc();
      @(negedge clk); #1;
      if (acc_last) in_valid = 1'b0;
      if (load_req) begin
         in_valid = 1'b1; in_even_word = ld_e; in_odd_word = ld_o; in_odd_entry = ld_oe;
         load_req = 0;
      end
      wb_valid = '0;
      if (wb_force) begin
         wb_valid[0] = 1'b1; wb_reg[0 +: RW] = wb_force_reg[RW-1:0]; wb_force = 0;
      end else if (wb_auto) begin
         for (int k = 0; k < NWB; k++) begin
            if ($urandom % 3 == 0) begin
               int st;
               st = int'($urandom % 16);
               for (int j = 0; j < 16; j++) begin
                  int r;
                  r = (st + j) % 16;
                  if (pend[r] && !(k == 1 && wb_valid[0] && int'(wb_reg[0 +: RW]) == r)) begin
                     wb_valid[k] = 1'b1; wb_reg[k*RW +: RW] = r[RW-1:0];
                     break;
                  end
               end
            end
         end
      end
      mem_gnt = (gmode == 0) ? 1'b0 : (gmode == 1) ? 1'b1 : 1'($urandom % 2);
      flush = flush_req; flush_req = 0;
      if (flush) qh = qt;
      #1;
      acc_last = in_valid && in_ready;
      if (acc_last) begin
         pid++;
         if (!in_odd_entry) push(in_even_word, 1'b0, pid);
         push(in_odd_word, 1'b1, pid);
      end
   endtask

   task automatic send(input logic [IW-1:0] e, input logic [IW-1:0] o, input bit oe);
      ld_e = e; ld_o = o; ld_oe = oe; load_req = 1;
      cyc();
   endtask

   task automatic drain();
      load_req = 0; wb_auto = 1; gmode = 1;
      repeat (40) cyc();
      chk(qh == qt, "R5", "queue drained", (qt - qh + QN) % QN, 0);
      wb_auto = 0;
   endtask

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #2;
      chk(!out_even_valid && !out_odd_valid, "R1", "outputs after reset", int'(out_even_valid), 0);
      chk(!mem_req, "R1", "mem_req after reset", int'(mem_req), 0);
      chk(in_ready, "R1", "in_ready after reset", int'(in_ready), 1);
      mon_en = 1;

      // R2: latency of a clean even/odd pair
      send(mk(0, 0, 1, 1, 2, 3), mk(1, 0, 1, 4, 5, 6), 0);
      cyc(); chk(!out_even_valid && !out_odd_valid, "R2", "early after edge 1", int'(out_even_valid), 0);
      cyc(); chk(!out_even_valid && !out_odd_valid, "R2", "early after edge 2", int'(out_even_valid), 0);
      cyc(); chk(out_even_valid && out_odd_valid, "R2", "dual dispatch after edge 3", int'(out_odd_valid), 1);
      drain();

      // R3: pair rule fails (both odd class)
      send(mk(1, 0, 0, 0, 2, 3), mk(1, 0, 0, 0, 5, 6), 0);
      repeat (3) cyc();
      chk(out_odd_valid && !out_even_valid && !out_odd_slot, "R3", "slot 0 alone on odd pipe", int'(out_odd_slot), 0);
      cyc();
      chk(out_odd_valid && out_odd_slot, "R3", "slot 1 next edge on odd pipe", int'(out_odd_slot), 1);
      drain();
      // R4: both even class, both on even pipe
      send(mk(0, 0, 0, 0, 2, 3), mk(0, 0, 0, 0, 5, 6), 0);
      repeat (3) cyc();
      chk(out_even_valid && !out_odd_valid && !out_even_slot, "R4", "slot 0 on even pipe", int'(out_even_slot), 0);
      cyc();
      chk(out_even_valid && out_even_slot, "R4", "slot 1 on even pipe", int'(out_even_slot), 1);
      drain();

      // R6: odd entry
      send(mk(0, 0, 0, 0, 2, 3), mk(1, 0, 0, 0, 5, 6), 1);
      repeat (3) cyc();
      chk(out_odd_valid && out_odd_slot && !out_even_valid, "R6", "only slot 1 dispatched", int'(out_even_valid), 0);
      cyc();
      chk(!out_even_valid && !out_odd_valid, "R6", "nothing after slot 1", int'(out_even_valid), 0);
      drain();

      // R7: memory wait for grant
      gmode = 0;
      send(mk(1, 1, 0, 0, 2, 3), mk(1, 0, 0, 0, 5, 6), 0);
      cyc(); cyc();
      chk(mem_req, "R7", "mem_req while waiting", int'(mem_req), 1);
      chk(!out_even_valid && !out_odd_valid, "R7", "no dispatch before grant", int'(out_odd_valid), 0);
      cyc();
      chk(!out_odd_valid, "R7", "still waiting at edge 3", int'(out_odd_valid), 0);
      gmode = 1;
      cyc();
      chk(!out_odd_valid, "R7", "grant not yet seen", int'(out_odd_valid), 0);
      cyc();
      chk(out_odd_valid && !out_odd_slot && out_odd_word[IW-2], "R7", "memory op after grant", int'(out_odd_valid), 1);
      drain();

      // R8 and R9: scoreboard stalls
      send(mk(0, 0, 1, 5, 10, 11), mk(1, 0, 0, 0, 12, 13), 0);
      repeat (3) cyc();
      chk(out_even_valid && out_odd_valid, "R8", "producer pair dispatched", int'(out_even_valid), 1);
      send(mk(0, 0, 0, 0, 5, 10), mk(1, 0, 0, 0, 12, 13), 0);
      repeat (5) cyc();
      chk(!out_even_valid && !out_odd_valid, "R8", "consumer held on busy r5", int'(out_even_valid), 0);
      wb_force = 1; wb_force_reg = 5;
      cyc(); cyc();
      chk(out_even_valid && out_odd_valid, "R8", "consumer on writeback edge", int'(out_even_valid), 1);
      drain();
      send(mk(0, 0, 1, 7, 1, 2), mk(1, 0, 0, 0, 7, 3), 0);
      repeat (3) cyc();
      chk(out_even_valid && !out_odd_valid, "R9", "dependent slot 1 not paired", int'(out_odd_valid), 0);
      cyc();
      chk(!out_odd_valid, "R9", "slot 1 waits for r7", int'(out_odd_valid), 0);
      wb_force = 1; wb_force_reg = 7;
      cyc(); cyc();
      chk(out_odd_valid && out_odd_slot, "R9", "slot 1 after writeback", int'(out_odd_valid), 1);
      drain();

      // R10 and R11: flush with a held pair and a captured pair
      gmode = 0;
      send(mk(1, 1, 0, 0, 2, 3), mk(1, 0, 0, 0, 4, 5), 0);
      cyc();
      send(mk(0, 0, 0, 0, 6, 7), mk(1, 0, 0, 0, 8, 9), 0);
      cyc(); cyc();
      chk(!in_ready, "R11", "backpressure with both stages full", int'(in_ready), 0);
      flush_req = 1;
      cyc();
      chk(!in_ready, "R11", "in_ready during flush", int'(in_ready), 0);
      gmode = 1;
      cyc();
      chk(!out_even_valid && !out_odd_valid, "R10", "nothing on flush edge", int'(out_odd_valid), 0);
      repeat (6) begin
         cyc();
         chk(!out_even_valid && !out_odd_valid, "R10", "flushed pairs stay gone", int'(out_odd_valid), 0);
      end
      drain();

      // Random phase
      gmode = 2; wb_auto = 1;
      for (int n = 0; n < 4000; n++) begin
         if (!in_valid && !load_req && ($urandom % 3 != 0)) begin
            ld_e = mk(1'($urandom % 2), ($urandom % 4) == 0, 1'($urandom % 2),
                      int'($urandom % 16), int'($urandom % 16), int'($urandom % 16));
            ld_o = mk(1'($urandom % 2), ($urandom % 4) == 0, 1'($urandom % 2),
                      int'($urandom % 16), int'($urandom % 16), int'($urandom % 16));
            ld_oe = ($urandom % 8) == 0;
            load_req = 1;
         end
         if ($urandom % 200 == 0) flush_req = 1;
         cyc();
      end
      drain();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      #750000;
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

endmodule